// File: doc/BRIEF.md
# ROM Checksum Verifier

The verifier walks a contiguous region of a read-only memory through a synchronous read port with one cycle of read latency. It folds every byte of the region into an 8-bit column sum, where each bit column is the parity (XOR) of that bit across all bytes. The region is declared good only when the finished sum is exactly all ones (8'hFF). A zero result or any other pattern is a failure.

A run is started with a single-cycle `start_i` that also presents the region's first address and its byte count. When the last byte has been folded in, the block raises `done_o` for one cycle, and `pass_o` carries the verdict in that cycle. The same unit is used for several memories in turn. A new run can be launched in the very cycle that reports the previous result, so a sequence of regions can be checked back to back.

Top module: `rom_sum_check`

## Requirements
- R1: After synchronous reset `done_o`, `pass_o`, `busy_o` and `mem_rd_o` are all 0.
- R2: A start seen while idle makes `busy_o` high in the next cycle. From that cycle, `mem_rd_o` is high for exactly `len_i` consecutive cycles, and `mem_addr_o` is `base_i`, `base_i+1`, … in ascending order, one address per cycle.
- R3: The sum is the bitwise XOR of every byte in the region. It starts from zero on each accepted start, so an earlier run has no effect on it.
- R4: `pass_o` is 1 in the done cycle when the region's XOR equals 8'hFF, and 0 for any other value, including 8'h00.
- R5: `done_o` is high for a single cycle. For a nonzero length that cycle comes two cycles after the cycle that issued the last address, which is `len_i+1` cycles after the cycle in which `busy_o` first rose.
- R6: `pass_o` is 0 in every cycle in which `done_o` is 0.
- R7: A start seen while `busy_o` is high is ignored. The addresses, the timing and the verdict of the run in progress are unchanged.
- R8: A start with `len_i` = 0 issues no reads and gives `done_o` one cycle after acceptance, with `pass_o` = 0.
- R9: A start seen in the done cycle (when `busy_o` is 0) is accepted, so runs can follow each other with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to check a region, sampled when idle |
| base_i | input | ADDR_W | First address of the region, sampled with the start |
| len_i | input | ADDR_W+1 | Number of bytes in the region, sampled with the start |
| mem_addr_o | output | ADDR_W | Read address to the memory |
| mem_rd_o | output | 1 | Read enable. Data is expected one cycle later |
| mem_data_i | input | DATA_W | Read data, valid in the cycle after a read |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse that ends a run |
| pass_o | output | 1 | Verdict, valid while `done_o` is high |

## Verification
For a start accepted at clock edge S, the reads are due in the cycles S through S+len−1. The verdict is due in cycle S+len+1, or in cycle S+1 for an empty region. `busy_o` covers cycles S to the cycle before the verdict. The bench's reference model works out these cycle numbers from its own count of clock edges and from its own copy of the memory image. At every falling edge it compares every output against the values expected for that cycle, so a result that arrives one cycle early or late is reported at once. An extra check at the end of each run compares the verdict with the value the bench expects for that region.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

    localparam int RCV_ADDR_W_DEF = 16;
    localparam int RCV_DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        RCV_IDLE  = 2'd0,
        RCV_READ  = 2'd1,
        RCV_DRAIN = 2'd2
    } rcv_state_e;

    typedef struct packed {
        logic load;
        logic issue;
        logic finish;
    } rcv_ctl_t;

    function automatic logic [1:0] rcv_state_bits(input rcv_state_e s);
        return 2'(s);
    endfunction

endpackage

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
    import rcv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     len_zero_i,
    input  logic     last_i,
    output rcv_ctl_t ctl_o,
    output logic     busy_o
);

    rcv_state_e state_q, state_d;

    always_comb begin
        ctl_o   = '0;
        state_d = state_q;
        unique case (state_q)
            RCV_IDLE: begin
                if (start_i) begin
                    ctl_o.load = 1'b1;
                    state_d    = len_zero_i ? RCV_DRAIN : RCV_READ;
                end
            end
            RCV_READ: begin
                ctl_o.issue = 1'b1;
                if (last_i) state_d = RCV_DRAIN;
            end
            RCV_DRAIN: begin
                ctl_o.finish = 1'b1;
                state_d      = RCV_IDLE;
            end
            default: state_d = RCV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RCV_IDLE;
        else     state_q <= state_d;
    end

    assign busy_o = (state_q != RCV_IDLE);

    // R7: a run in the middle of its reads keeps reading whatever start does
    a_r7_read_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == RCV_READ && !last_i) |=> (state_q == RCV_READ));

    // R9: the finishing cycle always returns control to idle
    a_r9_drain_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == RCV_DRAIN) |=> (rcv_state_bits(state_q) != rcv_state_bits(RCV_DRAIN)));

endmodule

// File: rtl/rcv_addr_gen.sv
module rcv_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              issue_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o,
    output logic              len_zero_o
);

    localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load_i) begin
            addr_q   <= base_i;
            remain_q <= len_i;
        end else if (issue_i) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    assign addr_o     = addr_q;
    assign last_o     = (remain_q == ONE_LEFT);
    assign len_zero_o = (len_i == '0);

    // R2: consecutive reads step the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !last_o) |=> (addr_o == $past(addr_o) + 1'b1));

    // R2: a read is never issued with nothing left to read
    a_r2_remain_live: assert property (@(posedge clk) disable iff (rst)
        issue_i |-> (remain_q != '0));

endmodule

// File: rtl/rcv_col_sum.sv
module rcv_col_sum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              rd_i,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              done_o,
    output logic              pass_o
);

    logic              rd_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_next;
    logic              done_q, pass_q;

    for (genvar b = 0; b < DATA_W; b++) begin : g_col
        assign acc_next[b] = acc_q[b] ^ (rd_q & data_i[b]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= 1'b0;
            acc_q  <= '0;
            done_q <= 1'b0;
            pass_q <= 1'b0;
        end else begin
            rd_q   <= rd_i;
            done_q <= finish_i;
            pass_q <= finish_i & (&acc_next);
            if (clear_i) acc_q <= '0;
            else         acc_q <= acc_next;
        end
    end

    assign done_o = done_q;
    assign pass_o = pass_q;

    // R6: a verdict never appears outside the done cycle
    a_r6_pass_with_done: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> done_o);

    // R5: done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/rom_sum_check.sv
module rom_sum_check
    import rcv_pkg::*;
#(
    parameter int ADDR_W = RCV_ADDR_W_DEF,
    parameter int DATA_W = RCV_DATA_W_DEF,
    localparam int LEN_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o
);

    rcv_ctl_t ctl;
    logic     last, len_zero;

    rcv_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .len_zero_i (len_zero),
        .last_i     (last),
        .ctl_o      (ctl),
        .busy_o     (busy_o)
    );

    rcv_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (ctl.load),
        .issue_i    (ctl.issue),
        .base_i     (base_i),
        .len_i      (len_i),
        .addr_o     (mem_addr_o),
        .last_o     (last),
        .len_zero_o (len_zero)
    );

    rcv_col_sum #(.DATA_W(DATA_W)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (ctl.load),
        .rd_i     (ctl.issue),
        .finish_i (ctl.finish),
        .data_i   (mem_data_i),
        .done_o   (done_o),
        .pass_o   (pass_o)
    );

    assign mem_rd_o = ctl.issue;

    // R2: reads only happen inside a run
    a_r2_rd_in_run: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> busy_o);

    // R8: an empty region reads nothing and finishes one cycle later as a failure
    a_r8_empty_region: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && len_i == '0) |=> (!mem_rd_o ##1 (done_o && !pass_o)));

    // R2: an accepted start makes the block busy in the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

endmodule

// File: tb/rom_sum_check_tb.sv
module rom_sum_check_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = AW + 1;
    localparam int MEM_N = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [LW-1:0] len = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [7:0]    mem_data = 8'h00;
    logic          busy, done, pass;

    logic [7:0] mem [MEM_N];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int s_cyc = -100;
    int due = -100;
    int m_len = 0;
    int m_base = 0;
    logic [7:0] m_sum = 8'h00;
    logic last_pass = 1'b0;
    logic saw_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_sum_check #(.ADDR_W(AW), .DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .base_i(base), .len_i(len),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_data_i(mem_data),
        .busy_o(busy), .done_o(done), .pass_o(pass)
    );

    always @(posedge clk) if (mem_rd) mem_data <= mem[int'(mem_addr) % MEM_N];

    function automatic logic [7:0] region_xor(int b, int n);
        logic [7:0] x = 8'h00;
        for (int i = 0; i < n; i++) x ^= mem[(b + i) % MEM_N];
        return x;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // reference model: advances once per rising edge
    always @(posedge clk) begin
        int prev;
        prev = cyc;
        cyc  = cyc + 1;
        if (rst) begin
            s_cyc = -100;
            due   = -100;
        end else if (start && !(prev >= s_cyc && prev < due)) begin
            s_cyc  = cyc;
            m_len  = int'(len);
            m_base = int'(base);
            due    = (m_len == 0) ? cyc + 1 : cyc + m_len + 1;
            m_sum  = region_xor(m_base, m_len);
        end
    end

    // compare every output each cycle, away from the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            logic e_busy, e_rd, e_done, e_pass;
            e_busy = (cyc >= s_cyc) && (cyc < due);
            e_rd   = (m_len > 0) && (cyc >= s_cyc) && (cyc < s_cyc + m_len);
            e_done = (cyc == due);
            e_pass = e_done && (m_sum == 8'hFF);
            chk("R7 busy", int'(busy), int'(e_busy));
            chk("R2 rd", int'(mem_rd), int'(e_rd));
            if (e_rd) chk("R2 addr", int'(mem_addr), (m_base + cyc - s_cyc) % (1 << AW));
            chk("R5 done", int'(done), int'(e_done));
            chk("R6 pass", int'(pass), int'(e_pass));
            if (done) begin
                saw_done  = 1'b1;
                last_pass = pass;
            end
        end
    end

    task automatic make_good(int b, int n);
        mem[(b + n - 1) % MEM_N] ^= region_xor(b, n) ^ 8'hFF;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!saw_done && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        if (!saw_done) chk("watchdog", 0, 1);
        @(negedge clk);
    endtask

    task automatic run(int b, int n, string req, logic exp_pass);
        @(negedge clk);
        saw_done = 1'b0;
        start = 1'b1;
        base  = AW'(b);
        len   = LW'(n);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(req, int'(last_pass), int'(exp_pass));
    endtask

    initial begin
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done), 0);
        chk("R1 pass", int'(pass), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 rd", int'(mem_rd), 0);

        // R4 good region
        make_good(16, 8);
        run(16, 8, "R4 verdict good", 1'b1);
        // R4 damaged region
        mem[18] ^= 8'h04;
        run(16, 8, "R4 verdict bad", 1'b0);
        // R4 all-zero sum fails
        for (int i = 0; i < 4; i++) mem[100 + i] = 8'h5A;
        run(100, 4, "R4 zero sum fails", 1'b0);
        // R3 single byte, sum equals that byte; fresh accumulator after a failure
        mem[200] = 8'hFF;
        run(200, 1, "R3 single byte", 1'b1);
        mem[200] = 8'h7F;
        run(200, 1, "R3 single byte bad", 1'b0);
        // R8 empty region
        run(300, 0, "R8 empty", 1'b0);

        // R7 start while busy is ignored
        make_good(400, 20);
        @(negedge clk);
        saw_done = 1'b0;
        start = 1'b1; base = AW'(400); len = LW'(20);
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; base = AW'(16); len = LW'(3);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R7 verdict kept", int'(last_pass), 1);

        // R9 back-to-back regions: start held high, accepted in each done cycle
        make_good(500, 6);
        make_good(600, 9);
        @(negedge clk);
        start = 1'b1; base = AW'(500); len = LW'(6);
        @(negedge clk);
        while (!done) @(negedge clk);
        chk("R9 first verdict", int'(pass), 1);
        base = AW'(600); len = LW'(9);
        @(negedge clk);
        start = 1'b0;
        chk("R9 next run busy", int'(busy), 1);
        saw_done = 1'b0;
        wait_done();
        chk("R9 second verdict", int'(last_pass), 1);

        // R3 long region, wrapping through the image
        make_good(900, 300);
        run(900, 300, "R3 long region", 1'b1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule